// File: doc/BRIEF.md
# Shared-Line Address/Data Bus Master

This controller runs a small management port on a PHY device whose register address and data travel over the same eight lines. A host presents one command at a time: reset the device, write a byte to a register, or read a byte back. The controller then produces the whole pin sequence. It drives the active-low select, the latch-enable pulse that makes the device capture the address, the active-low write and read strobes and the active-low reset. It also controls the direction of the shared lines.

The shared lines appear as three signals: an output value, an output enable and an input. The pad ring or the bench joins them into a tri-state bus. Every timed phase lasts `HOLD_CYC` system clocks. `busy` covers the whole sequence. A one-cycle `done` pulse ends each command, and on a read `rd_data` carries the sampled byte at that point.

Top module: `mux_bus_master`

## Requirements
- R1: `cmd_op` is encoded as 2'b01 reset, 2'b10 register write and 2'b11 register read. A command is taken when `cmd_valid` is high while `busy` is low. The code 2'b00 starts nothing.
- R2: While idle, and out of reset, the pins are `phy_cs_n`=1, `phy_ale`=0, `phy_wr_n`=1, `phy_rd_n`=1 and `phy_rst_n`=1, with `bus_oe`=0.
- R3: A reset command pulls `phy_cs_n` low and holds `phy_rst_n` low for `HOLD_CYC` cycles. It then raises `phy_rst_n` for one cycle with select still low, and then raises `phy_cs_n`. `busy` lasts `HOLD_CYC`+2 cycles.
- R4: A write drives the address onto the lines, with line i carrying address bit i, and raises `phy_ale` while the address is driven. It then drives the data byte, with line i carrying data bit i, pulses `phy_wr_n` low and finally releases select. `busy` lasts 2·`HOLD_CYC`+5 cycles.
- R5: A read drives and latches the address as a write does. It then lowers `phy_rd_n` and samples `bus_in` in the last cycle of the read strobe. `phy_rd_n` rises before `phy_cs_n` rises. `busy` lasts 2·`HOLD_CYC`+5 cycles.
- R6: `bus_oe` is low in every cycle in which `phy_rd_n` is low, and it was already low in the cycle before `phy_rd_n` falls.
- R7: No two of the four strobes (latch enable high, write low, read low, reset low) are active in the same cycle.
- R8: `done` is a one-cycle pulse in the cycle in which `phy_cs_n` returns high. `rd_data` holds the byte of the last read until the next read completes.
- R9: Every strobe phase (latch enable high, write low, read low, reset low) lasts exactly `HOLD_CYC` cycles.
- R10: `busy` is high from the cycle after a command is accepted through the select-release cycle. Commands presented while busy are dropped.
- R11: Against a PHY register file, a write of 0x02 to register 0x02 reads back as 0x02. Writing 0xFF and then 0x00 to one register reads back as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request strobe |
| cmd_op | input | 2 | Command code (R1) |
| cmd_addr | input | 8 | Register address |
| cmd_wdata | input | 8 | Write data byte |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Last byte read |
| phy_cs_n | output | 1 | Device select, active low |
| phy_ale | output | 1 | Address latch enable, active high |
| phy_wr_n | output | 1 | Write strobe, active low |
| phy_rd_n | output | 1 | Read strobe, active low |
| phy_rst_n | output | 1 | Device reset, active low |
| bus_out | output | 8 | Value driven onto the shared lines |
| bus_oe | output | 1 | Drive enable for the shared lines |
| bus_in | input | 8 | Value seen on the shared lines |

## Verification
Directed cases come first. The register 0x02 round trip and the 0xFF-then-0x00 overwrite separate correct address latching from a design that latches data as the address. A reset between two reads of a preset register shows that the reset sequence actually reaches the device. A random mix of writes and reads over a 16-register window hits the same register many times, so a wrong byte lane or a stale capture shows up as a read mismatch against a shadow copy. Two further patterns show that a no-op code and a second command issued mid-sequence leave every register and `rd_data` unchanged.

// File: rtl/mbm_pkg.sv
package mbm_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_RESET = 2'b01,
    OP_WRITE = 2'b10,
    OP_READ  = 2'b11
  } mbm_op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RST_LO, ST_RST_HI,
    ST_ADDR, ST_ALE, ST_ALE_OFF,
    ST_WDAT, ST_WR, ST_WR_OFF,
    ST_TURN, ST_RD, ST_RD_OFF,
    ST_END
  } mbm_state_e;

  typedef struct packed {
    logic cs_n;
    logic ale;
    logic wr_n;
    logic rd_n;
    logic rst_n;
    logic oe;
    logic sel_data;
  } pin_t;

  // states whose length is set by the hold timer
  function automatic logic is_hold(mbm_state_e s);
    return (s == ST_RST_LO) || (s == ST_ALE) || (s == ST_WR) || (s == ST_RD);
  endfunction

  function automatic mbm_state_e first_state(mbm_op_e op);
    return (op == OP_RESET) ? ST_RST_LO : ST_ADDR;
  endfunction

  function automatic mbm_state_e next_state(mbm_state_e s, mbm_op_e op);
    mbm_state_e n;
    case (s)
      ST_RST_LO:  n = ST_RST_HI;
      ST_RST_HI:  n = ST_END;
      ST_ADDR:    n = ST_ALE;
      ST_ALE:     n = ST_ALE_OFF;
      ST_ALE_OFF: n = (op == OP_READ) ? ST_TURN : ST_WDAT;
      ST_WDAT:    n = ST_WR;
      ST_WR:      n = ST_WR_OFF;
      ST_WR_OFF:  n = ST_END;
      ST_TURN:    n = ST_RD;
      ST_RD:      n = ST_RD_OFF;
      ST_RD_OFF:  n = ST_END;
      default:    n = ST_IDLE;
    endcase
    return n;
  endfunction

  // pin levels for each state
  function automatic pin_t pins_of(mbm_state_e s);
    pin_t p;
    p = '{cs_n: 1'b1, ale: 1'b0, wr_n: 1'b1, rd_n: 1'b1, rst_n: 1'b1, oe: 1'b0, sel_data: 1'b0};
    if (s != ST_IDLE && s != ST_END) p.cs_n = 1'b0;
    case (s)
      ST_RST_LO:               p.rst_n = 1'b0;
      ST_ADDR, ST_ALE_OFF:     p.oe    = 1'b1;
      ST_ALE:    begin p.oe = 1'b1; p.ale = 1'b1; end
      ST_WDAT, ST_WR_OFF: begin p.oe = 1'b1; p.sel_data = 1'b1; end
      ST_WR:     begin p.oe = 1'b1; p.sel_data = 1'b1; p.wr_n = 1'b0; end
      ST_RD:                   p.rd_n  = 1'b0;
      default: ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/mbm_hold_timer.sv
module mbm_hold_timer #(
  parameter int HOLD_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= RELOAD;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/mbm_seq.sv
module mbm_seq
  import mbm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       hold_done,
  output mbm_state_e state,
  output logic       advance,
  output logic       accept,
  output logic       sample,
  output logic       finish
);
  mbm_state_e nxt;
  mbm_op_e    op_q;
  mbm_op_e    op_in;

  assign op_in = mbm_op_e'(cmd_op);

  always_comb begin
    nxt     = state;
    advance = 1'b0;
    accept  = 1'b0;
    if (state == ST_IDLE) begin
      if (cmd_valid && op_in != OP_NONE) begin
        nxt     = first_state(op_in);
        advance = 1'b1;
        accept  = 1'b1;
      end
    end else if (!is_hold(state) || hold_done) begin
      nxt     = next_state(state, op_q);
      advance = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      op_q  <= OP_NONE;
    end else begin
      state <= nxt;
      if (accept) op_q <= op_in;
    end
  end

  assign sample = (state == ST_RD) && hold_done;
  assign finish = (state == ST_END);
endmodule

// File: rtl/mbm_lane.sv
module mbm_lane #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [DW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  input  logic          drive,
  input  logic          sel_data,
  input  logic          sample,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] addr_q, data_q, cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      cap_q  <= '0;
    end else begin
      if (accept) begin
        addr_q <= addr_in;
        data_q <= wdata_in;
      end
      if (sample) cap_q <= bus_in;
    end
  end

  // line i carries bit i of whichever byte is selected
  assign bus_out = !drive ? '0 : (sel_data ? data_q : addr_q);
  assign rd_data = cap_q;
endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master
  import mbm_pkg::*;
#(
  parameter int DW       = 8,
  parameter int HOLD_CYC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [DW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic          phy_cs_n,
  output logic          phy_ale,
  output logic          phy_wr_n,
  output logic          phy_rd_n,
  output logic          phy_rst_n,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  input  logic [DW-1:0] bus_in
);
  mbm_state_e state;
  logic       hold_done;
  logic       evt_advance;
  logic       evt_accept;
  logic       evt_sample;
  logic       evt_finish;
  pin_t       pins;

  mbm_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .hold_done (hold_done),
    .state     (state),
    .advance   (evt_advance),
    .accept    (evt_accept),
    .sample    (evt_sample),
    .finish    (evt_finish)
  );

  mbm_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (evt_advance),
    .expired (hold_done)
  );

  assign pins = pins_of(state);

  mbm_lane #(.DW(DW)) u_lane (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (evt_accept),
    .addr_in  (cmd_addr),
    .wdata_in (cmd_wdata),
    .drive    (pins.oe),
    .sel_data (pins.sel_data),
    .sample   (evt_sample),
    .bus_in   (bus_in),
    .bus_out  (bus_out),
    .rd_data  (rd_data)
  );

  assign phy_cs_n  = pins.cs_n;
  assign phy_ale   = pins.ale;
  assign phy_wr_n  = pins.wr_n;
  assign phy_rd_n  = pins.rd_n;
  assign phy_rst_n = pins.rst_n;
  assign bus_oe    = pins.oe;
  assign busy      = (state != ST_IDLE);
  assign done      = evt_finish;
endmodule

// File: rtl/mbm_checker.sv
module mbm_checker #(
  parameter int HOLD_CYC = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [1:0] cmd_op,
  input logic       busy,
  input logic       done,
  input logic       cs_n,
  input logic       ale,
  input logic       wr_n,
  input logic       rd_n,
  input logic       rst_pin_n,
  input logic       oe,
  input logic       evt_sample
);
  logic        any_strb;
  logic [31:0] run;

  assign any_strb = ale | ~wr_n | ~rd_n | ~rst_pin_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run <= '0;
    else if (any_strb) run <= run + 1;
    else               run <= '0;
  end

  AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cs_n && !ale && wr_n && rd_n && rst_pin_n && !oe)); // R2
  AST_SAMPLE_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_sample |-> (!rd_n && !cs_n)); // R5
  AST_NO_DRIVE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !oe); // R6
  AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> !$past(oe)); // R6
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ale, ~wr_n, ~rd_n, ~rst_pin_n}) <= 1); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> done); // R8
  AST_STROBE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(any_strb) |-> (run == HOLD_CYC)); // R9
  AST_BUSY_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(cmd_valid) && $past(cmd_op) != 2'b00)); // R10
endmodule

bind mux_bus_master mbm_checker #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .busy       (busy),
  .done       (done),
  .cs_n       (phy_cs_n),
  .ale        (phy_ale),
  .wr_n       (phy_wr_n),
  .rd_n       (phy_rd_n),
  .rst_pin_n  (phy_rst_n),
  .oe         (bus_oe),
  .evt_sample (evt_sample)
);

// File: tb/sim_mux_bus_master.sv
module sim_mux_bus_master;
  localparam int H = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [7:0] cmd_addr = 8'h00, cmd_wdata = 8'h00;
  logic       busy, done;
  logic [7:0] rd_data, bus_out, bus_in;
  logic       phy_cs_n, phy_ale, phy_wr_n, phy_rd_n, phy_rst_n, bus_oe;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  mux_bus_master #(.DW(8), .HOLD_CYC(H)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .phy_cs_n(phy_cs_n), .phy_ale(phy_ale),
    .phy_wr_n(phy_wr_n), .phy_rd_n(phy_rd_n), .phy_rst_n(phy_rst_n),
    .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural PHY register file
  logic [7:0] phy_reg [256];
  logic [7:0] shadow  [256];
  logic [7:0] lat = 8'h00;

  always @(negedge phy_ale) if (rst_n && !phy_cs_n) lat = bus_out;
  always @(posedge phy_wr_n) if (rst_n && !phy_cs_n) phy_reg[lat] = bus_out;
  always @(negedge clk) if (rst_n && !phy_rst_n)
    for (int i = 0; i < 256; i++) phy_reg[i] = 8'h00;
  assign bus_in = (!phy_rd_n && !phy_cs_n) ? phy_reg[lat] : 8'h00;

  // expected busy length: sum of the phase lengths of each sequence
  function automatic int exp_len(input logic [1:0] op);
    if (op == 2'b01) return H + 1 + 1;
    if (op == 2'b00) return 0;
    return 1 + H + 1 + 1 + H + 1 + 1;
  endfunction

  // pin monitor
  logic [7:0] cur_a = 8'h00;
  int  run [4];
  bit  prev_rd_n = 1'b1, prev_oe = 1'b0, prev_done = 1'b0;
  logic [3:0] act;
  assign act = {phy_ale, ~phy_wr_n, ~phy_rd_n, ~phy_rst_n};

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) run[k] = 0;
    end else begin
      for (int k = 0; k < 4; k++) begin
        if (act[k]) run[k]++;
        else if (run[k] != 0) begin
          chk(run[k] == H, "R9", "strobe phase length", run[k], H);
          run[k] = 0;
        end
      end
      if ($countones(act) > 1) chk(1'b0, "R7", "overlapping strobes", act, 0);
      if (!phy_rd_n && bus_oe) chk(1'b0, "R6", "drive during read", 1, 0);
      if (!phy_rd_n && prev_rd_n && prev_oe) chk(1'b0, "R6", "no turnaround cycle", 1, 0);
      if (done && prev_done) chk(1'b0, "R8", "done longer than one cycle", 2, 1);
      if (phy_ale && (!bus_oe || bus_out != cur_a))
        chk(1'b0, "R4", "address on lines during latch", bus_out, cur_a);
      prev_rd_n = phy_rd_n;
      prev_oe   = bus_oe;
      prev_done = done;
    end
  end

  task automatic do_cmd(input logic [1:0] op, input logic [7:0] a, input logic [7:0] d,
                        output logic [7:0] rdv, output int len, output int ndone,
                        output bit cs_at_done);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d; cur_a = a;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
    len = 0; ndone = 0; rdv = 8'h00; cs_at_done = 1'b0;
    while (busy && len < 1000) begin
      len++;
      if (done) begin ndone++; rdv = rd_data; cs_at_done = phy_cs_n; end
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input string req);
    logic [7:0] r; int len, nd; bit cs;
    do_cmd(2'b10, a, d, r, len, nd, cs);
    shadow[a] = d;
    chk(len == exp_len(2'b10), req, "write busy length", len, exp_len(2'b10));
    chk(nd == 1 && cs, "R8", "write done pulse at release", nd, 1);
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
    logic [7:0] r; int len, nd; bit cs;
    do_cmd(2'b11, a, 8'h00, r, len, nd, cs);
    chk(len == exp_len(2'b11), "R5", "read busy length", len, exp_len(2'b11));
    chk(nd == 1 && cs, "R8", "read done pulse at release", nd, 1);
    chk(r == exp, req, "read data", r, exp);
  endtask

  task automatic run_all();
    logic [7:0] r; int len, nd; bit cs;
    logic [7:0] hold_rd;
    for (int i = 0; i < 256; i++) begin
      phy_reg[i] = 8'(i) ^ 8'h5A;
      shadow[i]  = 8'(i) ^ 8'h5A;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2: reset and idle levels
    chk(phy_cs_n && !phy_ale && phy_wr_n && phy_rd_n && phy_rst_n && !bus_oe && !busy,
        "R2", "idle pin levels", {phy_cs_n, phy_ale, phy_wr_n, phy_rd_n, phy_rst_n, bus_oe, busy},
        7'b1011100);

    rd(8'h33, 8'h33 ^ 8'h5A, "R5");

    // R3: reset command clears the device
    do_cmd(2'b01, 8'h00, 8'h00, r, len, nd, cs);
    chk(len == exp_len(2'b01), "R3", "reset busy length", len, exp_len(2'b01));
    chk(nd == 1 && cs, "R3", "reset done at release", nd, 1);
    for (int i = 0; i < 256; i++) shadow[i] = 8'h00;
    rd(8'h33, 8'h00, "R3");

    // R11 directed round trips
    wr(8'h02, 8'h02, "R11");
    rd(8'h02, 8'h02, "R11");
    wr(8'h7E, 8'hFF, "R11");
    wr(8'h7E, 8'h00, "R11");
    rd(8'h7E, 8'h00, "R11");
    wr(8'hA5, 8'h96, "R4");
    rd(8'hA5, 8'h96, "R4");

    // R1: code 2'b00 starts nothing
    do_cmd(2'b00, 8'hA5, 8'h11, r, len, nd, cs);
    chk(len == 0 && nd == 0, "R1", "no-op code started a sequence", len, 0);
    rd(8'hA5, 8'h96, "R1");

    // R8: rd_data holds across a write
    hold_rd = rd_data;
    wr(8'h10, 8'h3C, "R4");
    chk(rd_data == hold_rd, "R8", "rd_data after write", rd_data, hold_rd);

    // R10: command during busy is dropped
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b10; cmd_addr = 8'h20; cmd_wdata = 8'h11; cur_a = 8'h20;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (2) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b10; cmd_addr = 8'h21; cmd_wdata = 8'hEE;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b00;
    while (busy) @(negedge clk);
    shadow[8'h20] = 8'h11;
    rd(8'h20, 8'h11, "R10");
    rd(8'h21, shadow[8'h21], "R10");

    // random mix over a small window
    for (int n = 0; n < 80; n++) begin
      logic [7:0] a, d;
      a = 8'h40 | 8'($urandom_range(0, 15));
      d = 8'($urandom);
      if ($urandom_range(0, 2) != 0) wr(a, d, "R4");
      else rd(a, shadow[a], "R5");
    end
  endtask

  bit timeout = 1'b0;

  initial begin
    void'($urandom(32'd20250611));
    fork
      run_all();
      begin repeat (150000) @(posedge clk); timeout = 1'b1; end
    join_any
    if (timeout) chk(1'b0, "R10", "watchdog expired", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule